// File: doc/BRIEF.md
# Latched Interrupt Aggregator

This block gathers event indications from a handful of slow sources into two banks of sticky interrupt flags, filters them through per-bit masks, and drives one active-low interrupt line toward a host. It watches two general-purpose inputs and an active-low enable pin in both directions. It records rising edges of two thermal-alarm levels and of a dropout level. It also latches single-cycle fault pulses from three switching regulators and one linear regulator. All inputs arrive already synchronized and debounced.

A host reaches the flags, the masks and a live status register through a simple synchronous read/write port. Reading a flag bank returns its contents and clears it in the same step. The interrupt line falls only when an unmasked flag makes a fresh 0-to-1 transition. Once low, it stays low until every flag in both banks is zero, masked flags included.

Top module: `irq_aggregator`

## Requirements
- R1: After synchronous reset, both flag banks read 0x00, mask bank 0 reads 0x7F, mask bank 1 reads 0x3F, `irq_n` is 1 and `rd_data` is 0x00.
- R2: Bank 0 records a fall of `gpi_in[0]` in bit 0, its rise in bit 1, a fall of `en_n_in` in bit 2 and its rise in bit 3. Bank 1 records a fall of `gpi_in[1]` in bit 0 and its rise in bit 1.
- R3: Bank 0 records a rising edge of `therm1_in` in bit 4, of `therm2_in` in bit 5 and of `dropout_in` in bit 6. Falling edges of these three levels set no flag.
- R4: Each cycle that `rfault_in[i]` is high sets bank 1 bit 2+i. Each cycle that `ldo_fault_in` is high sets bank 1 bit 5.
- R5: A set flag stays 1 until its own bank is read. The read returns the value held before the clear, and it leaves the other bank untouched.
- R6: An event that sets a flag in the same cycle its bank is read is kept: the read returns the older contents, and the new flag remains set afterwards.
- R7: A flag going from 0 to 1 while its mask bit (same position in the matching mask bank) is 0 drives `irq_n` low one clock edge after the event is sampled. A flag whose mask bit is 1 does not.
- R8: `irq_n` returns high only on the edge at which both flag banks become entirely zero, masked flags included.
- R9: Clearing a mask bit while its flag is already 1 does not drive `irq_n` low.
- R10: Writes to the flag banks and to the status register have no effect. Writes to mask banks store only the defined bits (bank 0 bits 6:0, bank 1 bits 5:0), and reserved bits read back 0.
- R11: The status register returns bit 0 = interrupt line asserted (inverse of `irq_n`), bit 1 = `therm1_in`, bit 2 = `therm2_in`, bit 3 = `dropout_in`, bit 4 = enable pin asserted (`en_n_in` low), and bits 7:5 = 0.
- R12: The address map is 0 = flag bank 0, 1 = flag bank 1, 2 = mask bank 0, 3 = mask bank 1, 4 = status. `rd_data` updates on the clock edge that samples `rd_en` and holds between reads. Other addresses read 0x00.
- R13: Input levels present while reset is released produce no flags. Only changes seen after reset count as edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gpi_in | input | 2 | General-purpose input levels, synchronized |
| en_n_in | input | 1 | Active-low enable pin level, debounced |
| therm1_in | input | 1 | Thermal alarm 1 level |
| therm2_in | input | 1 | Thermal alarm 2 level |
| dropout_in | input | 1 | Linear regulator dropout level |
| rfault_in | input | 3 | Switching regulator fault pulses |
| ldo_fault_in | input | 1 | Linear regulator fault pulse |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| irq_n | output | 1 | Active-low interrupt, registered |

## Verification
Each edge source is toggled in isolation in both directions, and the flag read back separates a correct bit position from a neighbouring one. Rising-only sources are also dropped, so that a detector triggering on any change is told apart from one on rises alone. Several levels move on a single edge, which shows that the banks accumulate and that the status register tracks live levels rather than latched ones. A masked flag is left pending while an unmasked one is cleared. A mask is opened over a flag that is already set. An event is made to coincide with a read. Together these separate transition-driven assertion of the line from level-driven assertion, and release on any clear from release on all-clear.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_FLAG0 = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_FLAG1 = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_MASK0 = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_MASK1 = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_STAT  = 3'd4;

  localparam int BANK0_USED = 7;
  localparam logic [DATA_W-1:0] BANK0_VALID = DATA_W'((1 << BANK0_USED) - 1);
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;
  logic         primed_q;

  always_ff @(posedge clk) begin
    prev_q <= lvl_i;
    if (rst) primed_q <= 1'b0;
    else     primed_q <= 1'b1;
  end

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_bit
      assign rise_o[g] = primed_q &  lvl_i[g] & ~prev_q[g];
      assign fall_o[g] = primed_q & ~lvl_i[g] &  prev_q[g];
    end
  endgenerate
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int          W     = 8,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] flags_q,
  output logic [W-1:0] flags_d,
  output logic [W-1:0] rose_o
);
  // Clear first, then OR in new events so a same-cycle event survives.
  assign flags_d = ((flags_q & ~{W{clr_i}}) | set_i) & VALID;
  assign rose_o  = flags_d & ~flags_q;

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_d;
  end
endmodule

// File: rtl/irq_line_ctl.sv
module irq_line_ctl (
  input  logic clk,
  input  logic rst,
  input  logic fresh_unmasked_i,
  input  logic all_clear_i,
  output logic irq_n_o
);
  always_ff @(posedge clk) begin
    if (rst)                   irq_n_o <= 1'b1;
    else if (fresh_unmasked_i) irq_n_o <= 1'b0;
    else if (all_clear_i)      irq_n_o <= 1'b1;
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int NUM_RFLT = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          gpi_in,
  input  logic                en_n_in,
  input  logic                therm1_in,
  input  logic                therm2_in,
  input  logic                dropout_in,
  input  logic [NUM_RFLT-1:0] rfault_in,
  input  logic                ldo_fault_in,
  input  logic                rd_en,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [DATA_W-1:0]   rd_data,
  output logic                irq_n
);
  localparam int BANK1_USED = 2 + NUM_RFLT + 1;
  localparam logic [DATA_W-1:0] BANK1_VALID = DATA_W'((1 << BANK1_USED) - 1);

  // Edge detection
  logic [2:0] pin_rise, pin_fall;
  logic [2:0] lvl_rise, unused_lvl_fall;

  irq_edge_det #(.W(3)) u_pin_edge (
    .clk(clk), .rst(rst), .lvl_i({en_n_in, gpi_in}),
    .rise_o(pin_rise), .fall_o(pin_fall)
  );

  irq_edge_det #(.W(3)) u_lvl_edge (
    .clk(clk), .rst(rst), .lvl_i({dropout_in, therm2_in, therm1_in}),
    .rise_o(lvl_rise), .fall_o(unused_lvl_fall)
  );

  // Event vectors per bank
  logic [DATA_W-1:0] set0, set1;
  always_comb begin
    set0    = '0;
    set0[0] = pin_fall[0];
    set0[1] = pin_rise[0];
    set0[2] = pin_fall[2];
    set0[3] = pin_rise[2];
    set0[6:4] = lvl_rise;
    set1    = '0;
    set1[0] = pin_fall[1];
    set1[1] = pin_rise[1];
    set1[2 +: NUM_RFLT] = rfault_in;
    set1[2 + NUM_RFLT]  = ldo_fault_in;
  end

  logic rd_flag0, rd_flag1;
  assign rd_flag0 = rd_en && (addr == ADDR_FLAG0);
  assign rd_flag1 = rd_en && (addr == ADDR_FLAG1);

  logic [DATA_W-1:0] flag0_q, flag0_d, rose0;
  logic [DATA_W-1:0] flag1_q, flag1_d, rose1;

  irq_flag_bank #(.W(DATA_W), .VALID(BANK0_VALID)) u_bank0 (
    .clk(clk), .rst(rst), .set_i(set0), .clr_i(rd_flag0),
    .flags_q(flag0_q), .flags_d(flag0_d), .rose_o(rose0)
  );

  irq_flag_bank #(.W(DATA_W), .VALID(BANK1_VALID)) u_bank1 (
    .clk(clk), .rst(rst), .set_i(set1), .clr_i(rd_flag1),
    .flags_q(flag1_q), .flags_d(flag1_d), .rose_o(rose1)
  );

  // Mask registers
  logic [DATA_W-1:0] mask0_q, mask1_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      mask0_q <= BANK0_VALID;
      mask1_q <= BANK1_VALID;
    end else if (wr_en) begin
      if (addr == ADDR_MASK0) mask0_q <= wr_data & BANK0_VALID;
      if (addr == ADDR_MASK1) mask1_q <= wr_data & BANK1_VALID;
    end
  end

  // Interrupt line
  logic fresh_unmasked, all_clear;
  assign fresh_unmasked = |(rose0 & ~mask0_q) || |(rose1 & ~mask1_q);
  assign all_clear      = (flag0_d == '0) && (flag1_d == '0);

  irq_line_ctl u_line (
    .clk(clk), .rst(rst),
    .fresh_unmasked_i(fresh_unmasked), .all_clear_i(all_clear),
    .irq_n_o(irq_n)
  );

  // Live status
  logic [DATA_W-1:0] stat;
  always_comb begin
    stat    = '0;
    stat[0] = ~irq_n;
    stat[1] = therm1_in;
    stat[2] = therm2_in;
    stat[3] = dropout_in;
    stat[4] = ~en_n_in;
  end

  // Read port
  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) begin
      case (addr)
        ADDR_FLAG0: rd_data <= flag0_q;
        ADDR_FLAG1: rd_data <= flag1_q;
        ADDR_MASK0: rd_data <= mask0_q;
        ADDR_MASK1: rd_data <= mask1_q;
        ADDR_STAT:  rd_data <= stat;
        default:    rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
  import irq_agg_pkg::*;
#(
  parameter logic [DATA_W-1:0] B1_VALID = 8'h3F
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              irq_n,
  input logic [DATA_W-1:0] flags0,
  input logic [DATA_W-1:0] flags1,
  input logic [DATA_W-1:0] mask0,
  input logic [DATA_W-1:0] mask1
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (flags0 == '0 && flags1 == '0 && mask0 == BANK0_VALID &&
             mask1 == B1_VALID && irq_n));

  assert_sticky_bank0_R5: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && addr == ADDR_FLAG0) |=> ((flags0 & $past(flags0)) == $past(flags0)));

  assert_sticky_bank1_R5: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && addr == ADDR_FLAG1) |=> ((flags1 & $past(flags1)) == $past(flags1)));

  assert_read_before_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_FLAG0) |=> (rd_data == $past(flags0)));

  assert_fall_needs_fresh_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_n) |-> (((flags0 & ~$past(flags0) & ~$past(mask0)) != '0) ||
                      ((flags1 & ~$past(flags1) & ~$past(mask1)) != '0)));

  assert_release_all_clear_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_n) |-> (flags0 == '0 && flags1 == '0));

  assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (rst)
    ((mask0 & ~BANK0_VALID) == '0) && ((mask1 & ~B1_VALID) == '0) &&
    ((flags0 & ~BANK0_VALID) == '0) && ((flags1 & ~B1_VALID) == '0));
endmodule

bind irq_aggregator irq_aggregator_chk #(.B1_VALID(BANK1_VALID)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .rd_data(rd_data),
  .irq_n(irq_n), .flags0(flag0_q), .flags1(flag1_q),
  .mask0(mask0_q), .mask1(mask1_q)
);

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] gpi_in = 2'b11;
  logic       en_n_in = 1'b1;
  logic       therm1_in = 1'b0, therm2_in = 1'b0, dropout_in = 1'b0;
  logic [2:0] rfault_in = 3'b000;
  logic       ldo_fault_in = 1'b0;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       irq_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  irq_aggregator i_irq_aggregator (
    .clk(clk), .rst(rst), .gpi_in(gpi_in), .en_n_in(en_n_in),
    .therm1_in(therm1_in), .therm2_in(therm2_in), .dropout_in(dropout_in),
    .rfault_in(rfault_in), .ldo_fault_in(ldo_fault_in),
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
    chk("R1 rd_data", rd_data, 8'h00);
    rd(3'd0, d); chk("R13 bank0 after reset with high inputs", d, 8'h00);
    rd(3'd1, d); chk("R1 bank1", d, 8'h00);
    rd(3'd2, d); chk("R1 mask0", d, 8'h7F);
    rd(3'd3, d); chk("R1 mask1", d, 8'h3F);
    tick(); gpi_in = 2'b00; tick();
    rd(3'd0, d); rd(3'd1, d);
  endtask

  task automatic t_edges();
    logic [7:0] d;
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    tick(); gpi_in[0] = 1'b1; tick();
    chk("R7 irq low on unmasked event", {7'd0, irq_n}, 8'h00);
    rd(3'd0, d); chk("R2 gpi0 rise", d, 8'h02);
    chk("R8 irq released after clear", {7'd0, irq_n}, 8'h01);
    tick(); gpi_in[0] = 1'b0; tick();
    rd(3'd0, d); chk("R2 gpi0 fall", d, 8'h01);
    tick(); en_n_in = 1'b0; tick();
    rd(3'd0, d); chk("R2 enable fall", d, 8'h04);
    tick(); en_n_in = 1'b1; tick();
    rd(3'd0, d); chk("R2 enable rise", d, 8'h08);
    tick(); gpi_in[1] = 1'b1; tick();
    rd(3'd1, d); chk("R2 gpi1 rise", d, 8'h02);
    tick(); gpi_in[1] = 1'b0; tick();
    rd(3'd1, d); chk("R2 gpi1 fall", d, 8'h01);
  endtask

  task automatic t_levels();
    logic [7:0] d;
    tick(); therm1_in = 1'b1; tick();
    rd(3'd0, d); chk("R3 therm1 rise", d, 8'h10);
    tick(); therm1_in = 1'b0; tick();
    rd(3'd0, d); chk("R3 therm1 fall sets nothing", d, 8'h00);
    tick(); therm1_in = 1'b1; therm2_in = 1'b1; dropout_in = 1'b1; en_n_in = 1'b0; tick();
    rd(3'd4, d); chk("R11 status all active", d, 8'h1F);
    rd(3'd0, d); chk("R3 therm2 dropout rise", d, 8'h74);
    rd(3'd4, d); chk("R11 status after clear", d, 8'h1E);
    tick(); therm1_in = 1'b0; therm2_in = 1'b0; dropout_in = 1'b0; en_n_in = 1'b1; tick();
    rd(3'd0, d); chk("R3 only enable rise after level drop", d, 8'h08);
  endtask

  task automatic t_faults();
    logic [7:0] d;
    tick(); rfault_in[1] = 1'b1; tick(); rfault_in[1] = 1'b0;
    rd(3'd1, d); chk("R4 single regulator fault", d, 8'h08);
    tick(); rfault_in = 3'b111; ldo_fault_in = 1'b1; tick();
    rfault_in = 3'b000; ldo_fault_in = 1'b0;
    rd(3'd1, d); chk("R4 all faults", d, 8'h3C);
  endtask

  task automatic t_sticky();
    logic [7:0] d;
    tick(); gpi_in[0] = 1'b1; rfault_in[0] = 1'b1; tick(); rfault_in[0] = 1'b0;
    repeat (5) tick();
    rd(3'd0, d); chk("R5 bank0 held", d, 8'h02);
    rd(3'd0, d); chk("R5 bank0 cleared by read", d, 8'h00);
    rd(3'd1, d); chk("R5 bank1 untouched by bank0 read", d, 8'h04);
  endtask

  task automatic t_same_cycle();
    logic [7:0] d;
    @(negedge clk); rd_en = 1'b1; addr = 3'd0; gpi_in[0] = 1'b0;
    @(negedge clk); rd_en = 1'b0;
    chk("R6 read returns older contents", rd_data, 8'h00);
    rd(3'd0, d); chk("R6 same-cycle event kept", d, 8'h01);
    tick(); gpi_in[0] = 1'b1; tick();
    @(negedge clk); rd_en = 1'b1; addr = 3'd0; gpi_in[0] = 1'b0;
    @(negedge clk); rd_en = 1'b0;
    chk("R6 read during event returns old flag", rd_data, 8'h02);
    rd(3'd0, d); chk("R6 fall survives concurrent read", d, 8'h01);
  endtask

  task automatic t_masking();
    logic [7:0] d;
    wr(3'd2, 8'h7F);
    tick(); gpi_in[0] = 1'b1; tick();
    chk("R7 masked event keeps irq high", {7'd0, irq_n}, 8'h01);
    wr(3'd2, 8'h00); tick();
    chk("R9 unmasking pending flag keeps irq high", {7'd0, irq_n}, 8'h01);
    rd(3'd0, d); chk("R9 pending flag still present", d, 8'h02);
    wr(3'd3, 8'h3F);
    tick(); rfault_in[0] = 1'b1; tick(); rfault_in[0] = 1'b0;
    chk("R7 masked fault keeps irq high", {7'd0, irq_n}, 8'h01);
    tick(); gpi_in[0] = 1'b0; tick();
    chk("R7 unmasked fall drives irq low", {7'd0, irq_n}, 8'h00);
    rd(3'd0, d); chk("R8 bank0 read", d, 8'h01);
    chk("R8 irq held by masked flag", {7'd0, irq_n}, 8'h00);
    rd(3'd1, d); chk("R8 bank1 read", d, 8'h04);
    chk("R8 irq released when all clear", {7'd0, irq_n}, 8'h01);
  endtask

  task automatic t_writes();
    logic [7:0] d;
    wr(3'd2, 8'hFF); rd(3'd2, d); chk("R10 mask0 reserved bit", d, 8'h7F);
    wr(3'd3, 8'hFF); rd(3'd3, d); chk("R10 mask1 reserved bits", d, 8'h3F);
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    wr(3'd0, 8'hFF);
    chk("R10 flag write leaves irq high", {7'd0, irq_n}, 8'h01);
    rd(3'd0, d); chk("R10 flag write ignored bank0", d, 8'h00);
    wr(3'd1, 8'hFF); rd(3'd1, d); chk("R10 flag write ignored bank1", d, 8'h00);
    wr(3'd4, 8'hFF); rd(3'd4, d); chk("R10 status write ignored", d, 8'h00);
    rd(3'd7, d); chk("R12 unused address", d, 8'h00);
    repeat (3) tick();
    chk("R12 rd_data holds between reads", rd_data, 8'h00);
    rd(3'd2, d); chk("R12 mask0 address", d, 8'h00);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    repeat (2) tick();
    t_reset();
    t_edges();
    t_levels();
    t_faults();
    t_sticky();
    t_same_cycle();
    t_masking();
    t_writes();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule